// File: doc/BRIEF.md
# Dual-Channel Edge/Center PWM Timer

This block is a 16-bit timer with a shared counter, a prescaler, a modulo limit and two compare channels. Each channel drives one PWM output and raises a flag on its compare events. The counter runs in one of two modes. In edge-aligned mode it counts up from 0 to the modulo limit and wraps. In center-aligned mode it counts up to the limit and then back down to 0. A single control register sets the mode, the clock source and the prescaler for every channel at once.

Software reaches the block over a synchronous register bus with one address, a write strobe and a read strobe. Flags are cleared by a two-step handshake: software first reads the flag while it is set, then writes 0 to it. The modulo and channel values are double-buffered. A new value only takes effect at a period boundary, so a PWM output never glitches mid-period.

Top module: `tpm_pwm`

## Requirements
- R1: After reset every register reads 0, both PWM outputs are low and `irq` is low. Read data appears on `bus_rdata` on the clock edge after the cycle in which `bus_rd` is high.
- R2: Address 0 is the timer control word: bit 7 overflow flag, bit 6 overflow interrupt enable, bit 5 center-aligned select, bits 4:3 clock source, bits 2:0 prescale select. The clock source codes are: 00 counter stopped, 01 every clock cycle, 10 each cycle with `tick_src[0]` high, 11 each cycle with `tick_src[1]` high. Address 1 is the counter, address 2 the modulo limit, address 3+2n the control word of channel n, and address 4+2n the value of channel n.
- R3: The prescale select PS divides the selected source by 2^PS, so the counter advances once every 2^PS source pulses.
- R4: In edge-aligned mode the counter goes 0, 1, ... up to the modulo limit, then wraps to 0. The wrap sets the overflow flag.
- R5: In center-aligned mode the counter counts up to the modulo limit and then down. The step that brings it back to 0 ends the period and sets the overflow flag. Each period lasts 2×limit counts.
- R6: A channel control word has bit 7 as the flag and bit 6 as the interrupt enable. In edge-aligned mode the flag is set once per period, when the counter reaches the channel value (the end of the high phase).
- R7: In center-aligned mode the flag is set on both matches, going up and going down. It is set once per period when the value equals the limit.
- R8: A PWM output is high while the counter is below the channel's active value, in either direction. A value of 0 keeps it low. A value above the limit keeps it high.
- R9: Writes to the modulo limit and the channel values are held and take effect at the next period boundary. While the clock source is 00 they take effect at once. Reads return the last written value.
- R10: A flag is cleared only by writing 0 to its bit after a read has seen it set. A 0 written without that read leaves it set. Any write to the register ends the armed state.
- R11: A flag event in the same cycle as a clearing write leaves the flag set.
- R12: `irq` is high when (overflow flag AND overflow enable) OR, for any channel, (flag AND enable).
- R13: A write to the counter address, or a write that changes the center-aligned select, restarts the counter at 0 counting up and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| tick_src | input | 2 | Alternative count enables for clock source codes 10 and 11 |
| pwm_out | output | 2 | PWM output per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
A source pulse seen at a rising edge updates the counter, the overflow flag and the channel flags at that same edge. The PWM outputs and `irq` follow combinationally from those registers. These results are therefore checked at the falling edge right after the pulse.

Register reads take one cycle. The scoreboard queues the expected word when the read strobe is driven and compares it at the falling edge after the capturing rising edge.

Prescaler ratios are measured as the difference between two counter reads taken exactly 32 cycles apart, so the prescaler phase does not affect the result.

// File: rtl/tpm_pwm.sv
module tpm_pwm #(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [1:0]     tick_src,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);

  localparam logic [AW-1:0] A_TSC = AW'(0);
  localparam logic [AW-1:0] A_CNT = AW'(1);
  localparam logic [AW-1:0] A_MOD = AW'(2);
  localparam int PW = 7;

  logic          tof, toie, cpwms, tof_arm;
  logic [1:0]    csel;
  logic [2:0]    ps;
  logic [PW-1:0] pre, mask;
  logic [CW-1:0] cnt, cnt_n, mod_buf, mod_act;
  logic          down, down_n, wrap, src_pulse, tick, restart, load;
  logic          wr_tsc, wr_cnt, wr_mod, rd_tsc;
  logic [NCH-1:0]    chf_v, chie_v;
  logic [NCH*CW-1:0] chvb_all, chva_all;
  logic [CW-1:0]     rd_mux;

  assign wr_tsc = bus_wr && bus_addr == A_TSC;
  assign wr_cnt = bus_wr && bus_addr == A_CNT;
  assign wr_mod = bus_wr && bus_addr == A_MOD;
  assign rd_tsc = bus_rd && bus_addr == A_TSC;

  always_comb begin
    case (csel)
      2'b01:   src_pulse = 1'b1;
      2'b10:   src_pulse = tick_src[0];
      2'b11:   src_pulse = tick_src[1];
      default: src_pulse = 1'b0;
    endcase
  end

  assign mask    = PW'((8'd1 << ps) - 8'd1);
  assign restart = wr_cnt || (wr_tsc && bus_wdata[5] != cpwms);
  assign tick    = src_pulse && ((pre & mask) == mask) && !restart;
  assign load    = (tick && wrap) || csel == 2'b00;

  always_comb begin
    cnt_n  = cnt;
    down_n = down;
    wrap   = 1'b0;
    if (!cpwms) begin
      if (cnt >= mod_act) begin
        cnt_n = '0;
        wrap  = 1'b1;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end else if (!down && cnt < mod_act) begin
      cnt_n = cnt + 1'b1;
    end else if (cnt <= CW'(1)) begin
      cnt_n  = '0;
      down_n = 1'b0;
      wrap   = 1'b1;
    end else begin
      cnt_n  = cnt - 1'b1;
      down_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
      pre  <= '0;
    end else if (restart) begin
      cnt  <= '0;
      down <= 1'b0;
      pre  <= '0;
    end else begin
      if (src_pulse) pre <= pre + 1'b1;
      if (tick) begin
        cnt  <= cnt_n;
        down <= down_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toie    <= 1'b0;
      cpwms   <= 1'b0;
      csel    <= 2'b00;
      ps      <= 3'd0;
      tof     <= 1'b0;
      tof_arm <= 1'b0;
      mod_buf <= '0;
      mod_act <= '0;
    end else begin
      if (wr_tsc) begin
        toie  <= bus_wdata[6];
        cpwms <= bus_wdata[5];
        csel  <= bus_wdata[4:3];
        ps    <= bus_wdata[2:0];
      end
      if (tick && wrap)                           tof <= 1'b1;
      else if (wr_tsc && !bus_wdata[7] && tof_arm) tof <= 1'b0;
      if (wr_tsc)             tof_arm <= 1'b0;
      else if (rd_tsc && tof) tof_arm <= 1'b1;
      else if (!tof)          tof_arm <= 1'b0;
      if (wr_mod) mod_buf <= bus_wdata;
      if (load)   mod_act <= mod_buf;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_SC = AW'(3 + 2 * i);
    localparam logic [AW-1:0] A_V  = AW'(4 + 2 * i);
    logic          f, en, arm, hit, wsc, wv, rsc;
    logic [CW-1:0] vb, va, eff;

    assign wsc = bus_wr && bus_addr == A_SC;
    assign wv  = bus_wr && bus_addr == A_V;
    assign rsc = bus_rd && bus_addr == A_SC;
    assign eff = load ? vb : va;
    assign hit = tick && cnt_n == eff;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f   <= 1'b0;
        en  <= 1'b0;
        arm <= 1'b0;
        vb  <= '0;
        va  <= '0;
      end else begin
        if (wsc)  en <= bus_wdata[6];
        if (wv)   vb <= bus_wdata;
        if (load) va <= vb;
        if (hit)                           f <= 1'b1;
        else if (wsc && !bus_wdata[7] && arm) f <= 1'b0;
        if (wsc)          arm <= 1'b0;
        else if (rsc && f) arm <= 1'b1;
        else if (!f)       arm <= 1'b0;
      end
    end

    assign pwm_out[i]              = cnt < va;
    assign chf_v[i]                = f;
    assign chie_v[i]               = en;
    assign chvb_all[i*CW +: CW]    = vb;
    assign chva_all[i*CW +: CW]    = va;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_TSC:   rd_mux = CW'({tof, toie, cpwms, csel, ps});
      A_CNT:   rd_mux = cnt;
      A_MOD:   rd_mux = mod_buf;
      default: rd_mux = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(3 + 2 * i)) rd_mux = CW'({chf_v[i], chie_v[i], 6'b0});
      if (bus_addr == AW'(4 + 2 * i)) rd_mux = chvb_all[i*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = (tof && toie) || |(chf_v & chie_v);

endmodule

// File: rtl/tpm_pwm_chk.sv
module tpm_pwm_chk #(
  parameter int CW  = 16,
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        csel,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     mod_act,
  input logic              tof,
  input logic [NCH-1:0]    chf_v,
  input logic [NCH*CW-1:0] chva_all,
  input logic [NCH-1:0]    pwm_out
);

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 2'b00 && !bus_wr) |=> $stable(cnt));

  // R4
  tof_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tof) |-> cnt == '0);

  // R9
  mod_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_act) |-> (cnt == '0 || $past(csel) == 2'b00));

  // R10
  tof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tof && !bus_wr) |=> tof);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R8
    pwm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chva_all[i*CW +: CW] == '0 |-> !pwm_out[i]);
    // R8
    pwm_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chva_all[i*CW +: CW] > mod_act && cnt <= mod_act) |-> pwm_out[i]);
    // R10
    chf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chf_v[i] && !bus_wr) |=> chf_v[i]);
  end

endmodule

bind tpm_pwm tpm_pwm_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .csel(csel), .cnt(cnt),
  .mod_act(mod_act), .tof(tof), .chf_v(chf_v), .chva_all(chva_all),
  .pwm_out(pwm_out)
);

// File: tb/tpm_pwm_tb.sv
`timescale 1ns/1ps
module tpm_pwm_tb;

  localparam logic [3:0] A_TSC = 4'd0, A_CNT = 4'd1, A_MOD = 4'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  tick_src = '0;
  logic [1:0]  pwm_out;
  logic        irq;

  always #2 clk = ~clk;

  tpm_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_src(tick_src), .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct {
    logic [15:0] exp;
    bit          care;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  logic [15:0] m_cnt, m_mod_a, m_mod_b;
  logic [15:0] m_va[2], m_vb[2];
  bit          m_down, m_cp, m_tof;
  bit          m_f[2], m_en[2];
  logic [6:0]  m_ctl;
  int          hw_tof, hw_f[2];

  function automatic logic [3:0] sc_a(int n); return 4'(3 + 2 * n); endfunction
  function automatic logic [3:0] v_a(int n);  return 4'(4 + 2 * n); endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard underrun", 0, 1);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.care) chk(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_push(logic [3:0] a, logic [15:0] e, bit care, string tag);
    item_t it;
    it.exp = e; it.care = care; it.tag = tag;
    @(negedge clk);
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_exp(logic [3:0] a, logic [15:0] e, string tag);
    rd_push(a, e, 1'b1, tag);
  endtask

  task automatic tk1();
    @(negedge clk);
    tick_src[0] = 1'b1;
    @(negedge clk);
    tick_src[0] = 1'b0;
  endtask

  task automatic model_tick();
    bit wrap = 1'b0;
    if (!m_cp) begin
      if (m_cnt >= m_mod_a) begin m_cnt = 0; wrap = 1'b1; end
      else m_cnt = m_cnt + 1;
    end else if (!m_down && m_cnt < m_mod_a) begin
      m_cnt = m_cnt + 1;
    end else if (m_cnt <= 1) begin
      m_cnt = 0; m_down = 1'b0; wrap = 1'b1;
    end else begin
      m_cnt = m_cnt - 1; m_down = 1'b1;
    end
    if (wrap) begin
      m_tof = 1'b1;
      m_mod_a = m_mod_b;
      for (int n = 0; n < 2; n++) m_va[n] = m_vb[n];
    end
    for (int n = 0; n < 2; n++) if (m_cnt == m_va[n]) m_f[n] = 1'b1;
  endtask

  function automatic bit exp_irq();
    return (m_tof && m_ctl[6]) || (m_f[0] && m_en[0]) || (m_f[1] && m_en[1]);
  endfunction

  task automatic post_tick_checks(string req, bit clr);
    for (int n = 0; n < 2; n++)
      chk(pwm_out[n] == (m_cnt < m_va[n]), {req, " R8 pwm"}, pwm_out[n], m_cnt < m_va[n]);
    chk(irq == exp_irq(), {req, " R12 irq"}, irq, exp_irq());
    rd_exp(A_CNT, m_cnt, {req, " counter"});
    rd_exp(A_TSC, {8'h0, m_tof, m_ctl}, {req, " overflow flag"});
    if (bus_rdata[7]) hw_tof++;
    for (int n = 0; n < 2; n++) begin
      rd_exp(sc_a(n), {8'h0, m_f[n], m_en[n], 6'b0}, {req, " channel flag"});
      if (bus_rdata[7]) hw_f[n]++;
    end
    if (clr) begin
      if (m_tof) begin wr(A_TSC, {9'h0, m_ctl}); m_tof = 1'b0; end
      for (int n = 0; n < 2; n++)
        if (m_f[n]) begin wr(sc_a(n), {9'h0, m_en[n], 6'b0}); m_f[n] = 1'b0; end
    end
  endtask

  task automatic step(string req, bit clr);
    tk1();
    model_tick();
    post_tick_checks(req, clr);
  endtask

  task automatic clear_all();
    rd_exp(A_TSC, {8'h0, m_tof, m_ctl}, "R10 clear prep");
    wr(A_TSC, {9'h0, m_ctl});
    m_tof = 1'b0;
    for (int n = 0; n < 2; n++) begin
      rd_exp(sc_a(n), {8'h0, m_f[n], m_en[n], 6'b0}, "R10 clear prep");
      wr(sc_a(n), {9'h0, m_en[n], 6'b0});
      m_f[n] = 1'b0;
    end
  endtask

  task automatic measure(string req, int exp_diff);
    logic [15:0] a, b;
    rd_push(A_CNT, 16'h0, 1'b0, "raw");
    a = bus_rdata;
    repeat (30) @(negedge clk);
    rd_push(A_CNT, 16'h0, 1'b0, "raw");
    b = bus_rdata;
    chk(16'(b - a) == 16'(exp_diff), req, 16'(b - a), exp_diff);
  endtask

  task automatic reset_hw_counts();
    hw_tof = 0; hw_f[0] = 0; hw_f[1] = 0;
  endtask

  initial begin
    m_cnt = 0; m_mod_a = 0; m_mod_b = 0; m_down = 0; m_cp = 0; m_tof = 0;
    m_ctl = 0;
    for (int n = 0; n < 2; n++) begin
      m_va[n] = 0; m_vb[n] = 0; m_f[n] = 0; m_en[n] = 0;
    end
    reset_hw_counts();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    chk(pwm_out == 2'b00, "R1 pwm after reset", pwm_out, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    rd_exp(A_TSC, 16'h0, "R1 control");
    rd_exp(A_CNT, 16'h0, "R1 counter");
    rd_exp(A_MOD, 16'h0, "R1 modulo");
    rd_exp(sc_a(0), 16'h0, "R1 channel control");
    rd_exp(v_a(1), 16'h0, "R1 channel value");

    wr(A_MOD, 16'd4);   m_mod_b = 4; m_mod_a = 4;
    wr(v_a(0), 16'd2);  m_vb[0] = 2; m_va[0] = 2;
    wr(v_a(1), 16'd5);  m_vb[1] = 5; m_va[1] = 5;
    wr(sc_a(0), 16'h40); m_en[0] = 1'b1;
    rd_exp(A_MOD, 16'd4, "R9 modulo readback");
    rd_exp(v_a(0), 16'd2, "R9 value readback");

    wr(A_TSC, 16'h10); m_ctl = 7'h10;
    reset_hw_counts();
    repeat (10) step("R4 R6 edge", 1'b1);
    chk(hw_f[0] == 2, "R6 edge flags per two periods", hw_f[0], 2);
    chk(hw_tof == 2, "R4 overflows in two periods", hw_tof, 2);
    chk(hw_f[1] == 0, "R8 value above limit never matches", hw_f[1], 0);

    wr(v_a(0), 16'd4); m_vb[0] = 4;
    wr(v_a(1), 16'd0); m_vb[1] = 0;
    rd_exp(v_a(0), 16'd4, "R9 buffered readback");
    repeat (10) step("R9 buffered", 1'b1);

    while (!m_f[0]) step("R10 prep", 1'b0);
    wr(sc_a(0), 16'hC0);
    wr(sc_a(0), 16'h40);
    rd_exp(sc_a(0), 16'hC0, "R10 zero without read ignored");
    wr(sc_a(0), 16'h40); m_f[0] = 1'b0;
    rd_exp(sc_a(0), 16'h40, "R10 read then zero clears");

    while (!m_f[0]) step("R11 prep", 1'b0);
    repeat (4) step("R11 prep", 1'b0);
    @(negedge clk);
    bus_addr = sc_a(0); bus_wdata = 16'h40; bus_wr = 1'b1; tick_src[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_src[0] = 1'b0;
    model_tick();
    chk(m_f[0] == 1'b1, "R11 model match", m_f[0], 1);
    rd_exp(sc_a(0), 16'hC0, "R11 set wins over clear");
    clear_all();

    wr(A_TSC, 16'h50); m_ctl = 7'h50;
    repeat (10) step("R12 overflow enable", 1'b1);
    wr(sc_a(0), 16'h00); m_en[0] = 1'b0;
    wr(A_TSC, 16'h10); m_ctl = 7'h10;
    repeat (5) step("R12 disabled", 1'b0);
    chk(irq == 1'b0, "R12 flags without enables", irq, 0);
    clear_all();

    wr(A_TSC, 16'h20); m_ctl = 7'h20; m_cp = 1'b1; m_cnt = 0; m_down = 1'b0;
    wr(A_MOD, 16'd4);  m_mod_b = 4; m_mod_a = 4;
    wr(v_a(0), 16'd2); m_vb[0] = 2; m_va[0] = 2;
    wr(v_a(1), 16'd4); m_vb[1] = 4; m_va[1] = 4;
    clear_all();
    wr(A_TSC, 16'h30); m_ctl = 7'h30;
    reset_hw_counts();
    repeat (16) step("R5 R7 center", 1'b1);
    chk(hw_f[0] == 4, "R7 two matches per period", hw_f[0], 4);
    chk(hw_f[1] == 2, "R7 single match at peak", hw_f[1], 2);
    chk(hw_tof == 2, "R5 overflow at end of down-count", hw_tof, 2);

    repeat (3) step("R13 prep", 1'b1);
    wr(A_CNT, 16'h0); m_cnt = 0; m_down = 1'b0;
    rd_exp(A_CNT, 16'h0, "R13 counter write restarts");
    step("R13 counts up after restart", 1'b1);
    repeat (5) step("R13 prep", 1'b1);
    wr(A_TSC, 16'h10); m_ctl = 7'h10; m_cp = 1'b0; m_cnt = 0; m_down = 1'b0;
    rd_exp(A_CNT, 16'h0, "R13 mode change restarts");
    step("R13 edge after switch", 1'b1);

    wr(A_TSC, 16'h00);
    wr(A_MOD, 16'hFFFF);
    wr(A_TSC, 16'h0A);
    wr(A_CNT, 16'h0);
    measure("R3 prescale by 4", 8);
    wr(A_TSC, 16'h08);
    measure("R2 every-cycle source", 32);
    wr(A_TSC, 16'h18);
    measure("R2 second source idle", 0);
    tick_src[1] = 1'b1;
    measure("R2 second source active", 32);
    tick_src[1] = 1'b0;
    wr(A_TSC, 16'h00);
    measure("R2 stopped", 0);

    done = 1'b1;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule